// File: doc/BRIEF.md
# I2C Slave Address-Match Responder

This block is the target side of an I2C port. It watches the open-drain clock and data lines and compares each calling address with a 7-bit own address held in a register. When the address matches, it acknowledges the call. It records that it was addressed and notes which direction the bus master asked for. It then moves one byte at a time between the bus and a data register under software control. It reports each completed byte through a status flag and an interrupt line.

After each ninth clock the slave holds the clock line low until software has handled the byte. It waits for a data-register write when the transmit control bit is set, or for a data-register read when that bit is clear. During data bytes the direction comes from the transmit control bit that software programs. The direction captured from the address byte applies only to the address cycle. A STOP or a repeated START always returns the slave to watching for its address. General call and 10-bit addressing are not supported.

Software sees four byte-wide registers, selected by `reg_addr`:
- 0 (own address): bits [6:0].
- 1 (control): bit 0 is the transmit select; bit 1 is the interrupt enable.
- 2 (status): bit 0 = addressed, bit 1 = captured R/W, bit 2 = byte complete, bit 3 = interrupt flag.
- 3 (data).

Top module: `i2cs_responder`

## Requirements
- R1: After reset, `scl_oe` and `sda_oe` are 0, `irq` is 0 and the status register reads 0.
- R2: An address byte is received MSB first. If its bits [7:1] equal own-address bits [6:0], the slave drives SDA low on the ninth clock. Status bit 0 (addressed) is then set and status bit 1 takes the byte's bit 0 (1 = master reads).
- R3: After a non-matching address byte the slave does not acknowledge, changes no status bit and drives neither line until the next START.
- R4: At the falling edge of the ninth clock of a matched address or of any data byte, status bit 3 (interrupt flag) and status bit 2 (complete) are set. `irq` equals the flag ANDed with control bit 1. Writing the status register with bit 3 = 0 clears the flag; nothing else clears it.
- R5: Any write to the control register clears status bit 0.
- R6: After each ninth clock that does not end the transfer, the slave holds SCL low. It releases SCL on a data-register write when control bit 0 = 1, or on a data-register read when control bit 0 = 0. That same access clears status bit 2.
- R7: When control bit 0 = 1, the byte written to the data register is shifted out MSB first, even if the captured R/W bit was 0.
- R8: When control bit 0 = 0, the slave acknowledges each received byte on its ninth clock. The byte then reads back from the data register.
- R9: In transmit, a master NACK on the ninth clock makes the slave release SDA and SCL and ignore the bus until a STOP or START.
- R10: A STOP, or a repeated START, returns the slave to address monitoring. A new matching address is then acknowledged.
- R11: A data-register access while the slave is not holding the clock after an addressed byte leaves both lines released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Sensed SCL line level |
| sda_i | input | 1 | Sensed SDA line level |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effect on data register only) |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach is the one where direction is decided by the control bit rather than by the captured R/W bit. The master calls with a write direction, and software then sets transmit and loads a byte while the clock is stretched. The bench drives this as a wired-AND bus model, with a master that waits on a stretched clock. The repeated-START recovery is reached by having the master NACK a transmitted byte and then re-address the slave without a STOP. The clock stretch is probed by raising the master's clock while the slave holds it and checking that the line stays low.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_HOLD,
        ST_DATA,
        ST_DATA_ACK,
        ST_SKIP
    } eng_state_e;

    localparam logic [1:0] RA_OWN  = 2'd0;
    localparam logic [1:0] RA_CTRL = 2'd1;
    localparam logic [1:0] RA_STAT = 2'd2;
    localparam logic [1:0] RA_DATA = 2'd3;

    typedef struct packed {
        logic ie;
        logic tx;
    } ctrl_t;

    typedef struct packed {
        logic flag;
        logic done;
        logic srw;
        logic aas;
    } stat_t;

endpackage

// File: rtl/i2cs_line_mon.sv
module i2cs_line_mon #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic line_i,
    output logic level,
    output logic rise,
    output logic fall
);
    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '1;
            prev_q <= 1'b1;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], line_i};
            prev_q <= sync_q[STAGES-1];
        end
    end

    assign level = sync_q[STAGES-1];
    assign rise  = level & ~prev_q;
    assign fall  = ~level & prev_q;
endmodule

// File: rtl/i2cs_engine.sv
module i2cs_engine
    import i2cs_pkg::*;
#(
    parameter int ADDR_W = 7,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_hi,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              sda_lvl,
    input  logic              sda_rise,
    input  logic              sda_fall,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              tx_mode,
    input  logic              data_wr,
    input  logic              data_rd,
    input  logic [DATA_W-1:0] wdata,
    output logic              ev_hit,
    output logic              ev_rw,
    output logic              ev_done,
    output logic              xfer_go,
    output logic [DATA_W-1:0] rx_byte,
    output logic              scl_oe,
    output logic              sda_oe
);
    localparam int CNT_W = $clog2(DATA_W + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W);

    eng_state_e        state;
    logic [DATA_W-1:0] shreg;
    logic [CNT_W-1:0]  cnt;
    logic              is_tx;
    logic              nack;
    logic              start_c;
    logic              stop_c;

    assign start_c = scl_hi & sda_fall;
    assign stop_c  = scl_hi & sda_rise;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            shreg   <= '0;
            cnt     <= '0;
            is_tx   <= 1'b0;
            nack    <= 1'b0;
            rx_byte <= '0;
            scl_oe  <= 1'b0;
            sda_oe  <= 1'b0;
            ev_hit  <= 1'b0;
            ev_rw   <= 1'b0;
            ev_done <= 1'b0;
            xfer_go <= 1'b0;
        end else begin
            ev_hit  <= 1'b0;
            ev_done <= 1'b0;
            xfer_go <= 1'b0;
            if (start_c) begin
                state  <= ST_ADDR;
                cnt    <= '0;
                scl_oe <= 1'b0;
                sda_oe <= 1'b0;
            end else if (stop_c) begin
                state  <= ST_IDLE;
                scl_oe <= 1'b0;
                sda_oe <= 1'b0;
            end else begin
                unique case (state)
                    ST_ADDR: begin
                        if (scl_rise) begin
                            shreg <= {shreg[DATA_W-2:0], sda_lvl};
                            cnt   <= cnt + 1'b1;
                        end else if (scl_fall && cnt == LAST) begin
                            if (shreg[DATA_W-1 -: ADDR_W] == own_addr) begin
                                sda_oe <= 1'b1;
                                ev_hit <= 1'b1;
                                ev_rw  <= shreg[0];
                                state  <= ST_ADDR_ACK;
                            end else begin
                                state <= ST_SKIP;
                            end
                        end
                    end
                    ST_ADDR_ACK: begin
                        if (scl_fall) begin
                            sda_oe  <= 1'b0;
                            scl_oe  <= 1'b1;
                            ev_done <= 1'b1;
                            state   <= ST_HOLD;
                        end
                    end
                    ST_HOLD: begin
                        if (tx_mode && data_wr) begin
                            shreg   <= wdata;
                            sda_oe  <= ~wdata[DATA_W-1];
                            scl_oe  <= 1'b0;
                            cnt     <= '0;
                            is_tx   <= 1'b1;
                            xfer_go <= 1'b1;
                            state   <= ST_DATA;
                        end else if (!tx_mode && data_rd) begin
                            scl_oe  <= 1'b0;
                            cnt     <= '0;
                            is_tx   <= 1'b0;
                            xfer_go <= 1'b1;
                            state   <= ST_DATA;
                        end
                    end
                    ST_DATA: begin
                        if (scl_rise) begin
                            if (!is_tx) shreg <= {shreg[DATA_W-2:0], sda_lvl};
                            cnt <= cnt + 1'b1;
                        end else if (scl_fall) begin
                            if (cnt == LAST) begin
                                state <= ST_DATA_ACK;
                                if (is_tx) begin
                                    sda_oe <= 1'b0;
                                end else begin
                                    sda_oe  <= 1'b1;
                                    rx_byte <= shreg;
                                end
                            end else if (is_tx) begin
                                shreg  <= shreg << 1;
                                sda_oe <= ~shreg[DATA_W-2];
                            end
                        end
                    end
                    ST_DATA_ACK: begin
                        if (scl_rise) begin
                            nack <= sda_lvl;
                        end else if (scl_fall) begin
                            sda_oe  <= 1'b0;
                            ev_done <= 1'b1;
                            if (is_tx && nack) begin
                                state <= ST_SKIP;
                            end else begin
                                scl_oe <= 1'b1;
                                state  <= ST_HOLD;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    AST_SDA_STEADY_SCL_HIGH: assert property (@(posedge clk) disable iff (rst)
        (scl_hi && $past(scl_hi) && !$past(start_c) && !$past(stop_c)) |-> $stable(sda_oe)); // R7
    AST_QUIET_UNADDRESSED: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE || state == ST_SKIP || state == ST_ADDR) |-> (!sda_oe && !scl_oe)); // R3
    AST_STRETCH_IN_HOLD: assert property (@(posedge clk) disable iff (rst)
        scl_oe |-> (state == ST_HOLD)); // R6
endmodule

// File: rtl/i2cs_responder.sv
module i2cs_responder
    import i2cs_pkg::*;
#(
    parameter int ADDR_W      = 7,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        scl_i,
    input  logic        sda_i,
    output logic        scl_oe,
    output logic        sda_oe,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic [1:0]  reg_addr,
    input  logic [7:0]  reg_wdata,
    output logic [7:0]  reg_rdata,
    output logic        irq
);
    localparam int NLINES = 2;

    logic [NLINES-1:0] line_in, lvl, rise, fall;
    assign line_in = {sda_i, scl_i};

    genvar gi;
    generate
        for (gi = 0; gi < NLINES; gi++) begin : g_mon
            i2cs_line_mon #(.STAGES(SYNC_STAGES)) u_mon (
                .clk(clk), .rst(rst), .line_i(line_in[gi]),
                .level(lvl[gi]), .rise(rise[gi]), .fall(fall[gi])
            );
        end
    endgenerate

    logic [ADDR_W-1:0] own_q;
    ctrl_t             ctrl_q;
    stat_t             stat_q;
    logic              ev_hit, ev_rw, ev_done, xfer_go;
    logic [DATA_W-1:0] rx_byte;
    logic              wr_ctrl, wr_stat;

    assign wr_ctrl = reg_wr && reg_addr == RA_CTRL;
    assign wr_stat = reg_wr && reg_addr == RA_STAT;

    i2cs_engine #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_eng (
        .clk(clk), .rst(rst),
        .scl_hi(lvl[0]), .scl_rise(rise[0]), .scl_fall(fall[0]),
        .sda_lvl(lvl[1]), .sda_rise(rise[1]), .sda_fall(fall[1]),
        .own_addr(own_q), .tx_mode(ctrl_q.tx),
        .data_wr(reg_wr && reg_addr == RA_DATA),
        .data_rd(reg_rd && reg_addr == RA_DATA),
        .wdata(reg_wdata[DATA_W-1:0]),
        .ev_hit(ev_hit), .ev_rw(ev_rw), .ev_done(ev_done), .xfer_go(xfer_go),
        .rx_byte(rx_byte), .scl_oe(scl_oe), .sda_oe(sda_oe)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            own_q  <= '0;
            ctrl_q <= '0;
            stat_q <= '0;
        end else begin
            if (reg_wr && reg_addr == RA_OWN) own_q <= reg_wdata[ADDR_W-1:0];
            if (wr_ctrl) ctrl_q <= ctrl_t'(reg_wdata[1:0]);
            if (ev_hit) begin
                stat_q.aas <= 1'b1;
                stat_q.srw <= ev_rw;
            end else if (wr_ctrl) begin
                stat_q.aas <= 1'b0;
            end
            if (ev_done)      stat_q.done <= 1'b1;
            else if (xfer_go) stat_q.done <= 1'b0;
            if (ev_done)                      stat_q.flag <= 1'b1;
            else if (wr_stat && !reg_wdata[3]) stat_q.flag <= 1'b0;
        end
    end

    always_comb begin
        unique case (reg_addr)
            RA_OWN:  reg_rdata = 8'(own_q);
            RA_CTRL: reg_rdata = 8'(ctrl_q);
            RA_STAT: reg_rdata = 8'(stat_q);
            default: reg_rdata = 8'(rx_byte);
        endcase
    end

    assign irq = stat_q.flag & ctrl_q.ie;

    AST_CTRL_WR_CLEARS_AAS: assert property (@(posedge clk) disable iff (rst)
        (wr_ctrl && !ev_hit) |=> !stat_q.aas); // R5
    AST_FLAG_NEEDS_BYTE_END: assert property (@(posedge clk) disable iff (rst)
        $rose(stat_q.flag) |-> $past(ev_done)); // R4
    AST_SRW_ONLY_ON_ADDR: assert property (@(posedge clk) disable iff (rst)
        !$stable(stat_q.srw) |-> stat_q.aas); // R2
endmodule

// File: tb/i2cs_responder_test.sv
module i2cs_responder_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       m_scl = 1'b1, m_sda = 1'b1;
    logic       scl_oe, sda_oe, irq;
    logic       reg_wr = 1'b0, reg_rd = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'd0, reg_rdata;
    logic       scl_line, sda_line;

    int n_cmp = 0, n_bad = 0;
    bit chk_en = 1'b0;
    bit finished = 1'b0;

    // reference model of software-visible state
    bit m_aas, m_srw, m_done, m_if, m_ie, m_tx, m_hold;

    assign scl_line = m_scl & ~scl_oe;
    assign sda_line = m_sda & ~sda_oe;

    always #10 clk = ~clk;

    i2cs_responder uut (
        .clk(clk), .rst(rst), .scl_i(scl_line), .sda_i(sda_line),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %02h expected %02h", tag, got, exp);
        end
    endtask

    function automatic logic [7:0] exp_stat();
        return {4'd0, m_if, m_done, m_srw, m_aas};
    endfunction

    // per-clock comparison of interrupt and stretch against the model (R4, R6)
    always @(posedge clk) begin
        if (chk_en) begin
            n_cmp++;
            if (irq !== (m_if & m_ie) || scl_oe !== m_hold) begin
                n_bad++;
                $display("FAIL R4/R6 per-clock: irq=%b scl_oe=%b expected irq=%b scl_oe=%b",
                         irq, scl_oe, m_if & m_ie, m_hold);
            end
        end
    end

    task automatic reg_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
        case (a)
            2'd1: begin m_aas = 1'b0; m_tx = d[0]; m_ie = d[1]; end
            2'd2: if (!d[3]) m_if = 1'b0;
            2'd3: if (m_hold && m_tx) begin m_done = 1'b0; m_hold = 1'b0; end
            default: ;
        endcase
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
        if (a == 2'd3 && m_hold && !m_tx) begin m_done = 1'b0; m_hold = 1'b0; end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        chk_en = 1'b0;
        m_sda = 1'b1; wait_clk(5);
        m_scl = 1'b1; wait_clk(10);
        m_sda = 1'b0; wait_clk(10);
        m_scl = 1'b0; wait_clk(5);
    endtask

    task automatic bus_stop();
        chk_en = 1'b0;
        m_sda = 1'b0; wait_clk(5);
        m_scl = 1'b1;
        while (scl_line !== 1'b1) @(negedge clk);
        wait_clk(10);
        m_sda = 1'b1; wait_clk(10);
    endtask

    task automatic bus_bit(input logic b, output logic r);
        m_sda = b; wait_clk(10);
        m_scl = 1'b1;
        while (scl_line !== 1'b1) @(negedge clk);
        wait_clk(5);
        r = sda_line;
        wait_clk(5);
        m_scl = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] v, output logic ack_n);
        logic r;
        chk_en = 1'b0;
        for (int i = 7; i >= 0; i--) bus_bit(v[i], r);
        bus_bit(1'b1, ack_n);
    endtask

    task automatic read_byte(input logic nack, output logic [7:0] v);
        logic r;
        chk_en = 1'b0;
        v = 8'd0;
        for (int i = 0; i < 8; i++) begin
            bus_bit(1'b1, r);
            v = {v[6:0], r};
        end
        bus_bit(nack, r);
    endtask

    // model update after a ninth clock completed on an addressed transfer
    task automatic byte_end(input bit holds);
        wait_clk(8);
        m_if = 1'b1; m_done = 1'b1; m_hold = holds;
        chk_en = 1'b1;
    endtask

    task automatic settle();
        wait_clk(8);
        chk_en = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic       a;
        logic [7:0] d;
        {m_aas, m_srw, m_done, m_if, m_ie, m_tx, m_hold} = '0;
        wait_clk(5);
        rst = 1'b0;
        wait_clk(2);
        chk_en = 1'b1;

        // R1 reset state
        check("R1 scl_oe", {7'd0, scl_oe}, 8'd0);
        check("R1 sda_oe", {7'd0, sda_oe}, 8'd0);
        check("R1 irq", {7'd0, irq}, 8'd0);
        reg_read(2'd2, d); check("R1 status", d, 8'd0);

        reg_write(2'd0, 8'h3A);
        reg_write(2'd1, 8'h02);

        // R3 non-matching address
        bus_start();
        send_byte(8'h76, a);
        check("R3 no ack", {7'd0, a}, 8'd1);
        settle();
        reg_read(2'd2, d); check("R3 status untouched", d, exp_stat());
        // R11 data access while not holding
        reg_write(2'd3, 8'h00);
        reg_read(2'd3, d);
        check("R11 scl released", {7'd0, scl_oe}, 8'd0);
        check("R11 sda released", {7'd0, sda_oe}, 8'd0);
        bus_stop();
        settle();

        // R2 match, master writes: slave receives (R8)
        bus_start();
        send_byte(8'h74, a);
        check("R2 ack", {7'd0, a}, 8'd0);
        m_aas = 1'b1; m_srw = 1'b0;
        byte_end(1'b1);
        reg_read(2'd2, d); check("R2/R4 status after address", d, exp_stat());
        check("R4 irq with enable", {7'd0, irq}, 8'd1);
        // R6 stretch: master releases SCL, line must stay low
        m_scl = 1'b1; wait_clk(20);
        check("R6 scl held low", {7'd0, scl_line}, 8'd0);
        m_scl = 1'b0; wait_clk(2);
        reg_write(2'd1, 8'h02);
        reg_read(2'd2, d); check("R5 ctrl write clears addressed", d, exp_stat());
        reg_write(2'd2, 8'h00);
        reg_read(2'd2, d); check("R4 flag cleared by status write", d, exp_stat());
        reg_read(2'd3, d); // dummy read releases
        reg_read(2'd2, d); check("R6 complete cleared by dummy read", d, exp_stat());
        send_byte(8'hA5, a);
        check("R8 ack byte 1", {7'd0, a}, 8'd0);
        byte_end(1'b1);
        reg_read(2'd2, d); check("R4 status after byte", d, exp_stat());
        reg_write(2'd2, 8'h08);
        reg_read(2'd2, d); check("R4 writing 1 keeps flag", d, exp_stat());
        reg_write(2'd2, 8'h00);
        reg_read(2'd3, d); check("R8 received byte 1", d, 8'hA5);
        send_byte(8'h5C, a);
        check("R8 ack byte 2", {7'd0, a}, 8'd0);
        byte_end(1'b1);
        reg_write(2'd2, 8'h00);
        reg_read(2'd3, d); check("R8 received byte 2", d, 8'h5C);
        bus_stop();
        settle();

        // R10 after STOP: master reads, slave transmits (R7, R9)
        bus_start();
        send_byte(8'h75, a);
        check("R10 ack after stop", {7'd0, a}, 8'd0);
        m_aas = 1'b1; m_srw = 1'b1;
        byte_end(1'b1);
        reg_read(2'd2, d); check("R2 read direction captured", d, exp_stat());
        reg_write(2'd1, 8'h03);
        reg_write(2'd2, 8'h00);
        reg_read(2'd2, d); check("R5 cleared, srw kept", d, exp_stat());
        reg_write(2'd3, 8'hC3);
        read_byte(1'b0, d);
        check("R7 transmitted byte 1", d, 8'hC3);
        byte_end(1'b1);
        reg_read(2'd2, d); check("R4 status after tx byte", d, exp_stat());
        reg_write(2'd2, 8'h00);
        reg_write(2'd3, 8'h81);
        read_byte(1'b1, d);
        check("R7 transmitted byte 2", d, 8'h81);
        byte_end(1'b0);
        check("R9 sda released after nack", {7'd0, sda_oe}, 8'd0);
        check("R9 scl released after nack", {7'd0, scl_oe}, 8'd0);
        reg_write(2'd2, 8'h00);
        bus_stop();
        settle();

        // R7 direction from control bit with write call; R10 repeated start
        reg_write(2'd1, 8'h02);
        bus_start();
        send_byte(8'h74, a);
        check("R2 ack write call", {7'd0, a}, 8'd0);
        m_aas = 1'b1; m_srw = 1'b0;
        byte_end(1'b1);
        reg_write(2'd1, 8'h01);
        check("R4 irq masked by enable", {7'd0, irq}, 8'd0);
        reg_write(2'd2, 8'h00);
        reg_write(2'd3, 8'h96);
        read_byte(1'b1, d);
        check("R7 tx bit overrides srw", d, 8'h96);
        byte_end(1'b0);
        reg_write(2'd2, 8'h00);
        bus_start();
        send_byte(8'h75, a);
        check("R10 ack after repeated start", {7'd0, a}, 8'd0);
        m_aas = 1'b1; m_srw = 1'b1;
        byte_end(1'b1);
        reg_read(2'd2, d); check("R10 status after repeated start", d, exp_stat());
        reg_write(2'd3, 8'h7E);
        read_byte(1'b1, d);
        check("R7 transmitted after repeated start", d, 8'h7E);
        byte_end(1'b0);
        bus_stop();
        settle();
        check("R10 lines idle at end", {6'd0, scl_oe, sda_oe}, 8'd0);

        chk_en = 1'b0;
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule